// File: doc/BRIEF.md
# TDM Time-Slot and Sub-Slot Assigner

This block connects four subscriber lines to a shared time-division multiplexed serial bus. Each line has two byte-wide bearer channels (B1, B2) and a 2-bit-per-frame signalling channel (D). The bearer bytes of all lines share one serial input and one serial output. The signalling bits use a second serial pair, placed at 2-bit sub-slot granularity. A frame holds up to 64 byte slots, which is 256 sub-slots at a 4.096 MHz bit clock.

Each line has six assignment entries. Three of them are capture entries, for B1, B2 and D taken from the serial inputs. The other three are drive entries, for B1, B2 and D put onto the serial outputs. Each entry holds an enable flag and a slot or sub-slot number, and is written through a simple parallel port.

The block runs on a fast system clock. The bit clock and frame sync are sampled as synchronous inputs. Each output changes in the system cycle after the bit-clock rise has been seen, and each input is captured at a bit-clock fall. Captured data reaches the line side one frame later, together with a valid pulse. Drive data is taken from the line side at each frame start. An output enable marks every bit the block actually drives.

Top module: `tdm_slot_mapper`

## Requirements
- R1: During and after reset: `ser_b_oe`, `ser_d_oe`, `ser_b_out`, `ser_d_out` and `par_valid` are low; `par_b_cap` and `par_d_cap` are zero; all assignment entries are disabled.
- R2: A frame starts at the first bit-clock rise at which `fsync` is high after it was low at the previous rise. That rise carries bit 0 of slot 0, and each later rise advances one bit. Holding `fsync` high over several rises starts only one frame. Past MAX_SLOTS*8 bits, nothing matches until the next frame start.
- R3: An enabled drive-B1 or drive-B2 entry of line `l` with slot `s` drives bits 8s..8s+7 on `ser_b_out`, MSB first, with `ser_b_oe` high. The byte is taken from `par_b_drv[(2*l+ch)*8 +: 8]` (ch 0 = B1, 1 = B2), sampled at frame start. Outputs change only after a bit-clock rise.
- R4: An enabled capture-B entry with slot `s` shifts in `ser_b_in` at the bit-clock falls of bits 8s..8s+7, MSB first. The byte appears on `par_b_cap` (same field layout as R3) at the next frame start. A channel that captured nothing keeps its previous value.
- R5: An enabled drive-D entry of line `l` with sub-slot `k` drives bits 2k and 2k+1 on `ser_d_out` with `ser_d_oe` high: first `par_d_drv[2*l+1]`, then `par_d_drv[2*l]`, sampled at frame start.
- R6: An enabled capture-D entry with sub-slot `k` samples `ser_d_in` at the falls of bits 2k and 2k+1, first bit into `par_d_cap[2*l+1]`. The pair is delivered at the next frame start and is held otherwise.
- R7: `ser_b_oe` and `ser_d_oe` are low in every bit not covered by an enabled, matching drive entry, including every bit before the first frame.
- R8: When several enabled drive entries claim the same bit, the lowest line wins, and within a line B1 wins over B2.
- R9: Let L be the length in bits of the previous frame (MAX_SLOTS*8 for the first frame after reset). Slot `s` matches only if 8s+8 <= L, and sub-slot `k` matches only if 2k+2 <= L.
- R10: `par_valid` pulses high for one clock at each frame start, except the first frame start after reset.
- R11: A write happens when `cfg_we` is high at a clock edge. `cfg_wdata[8]` is the enable and `cfg_wdata[7:0]` is the number. The address is line*6+kind, with kind 0 capture B1, 1 capture B2, 2 capture D, 3 drive B1, 4 drive B2, 5 drive D. Addresses 24 and above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Bit clock, sampled by clk |
| fsync | input | 1 | Frame sync, sampled at bit-clock rises |
| ser_b_in | input | 1 | Serial bearer input from the bus |
| ser_d_in | input | 1 | Serial signalling input from the bus |
| ser_b_out | output | 1 | Serial bearer output to the bus |
| ser_b_oe | output | 1 | Bearer output enable (low = high impedance) |
| ser_d_out | output | 1 | Serial signalling output to the bus |
| ser_d_oe | output | 1 | Signalling output enable |
| cfg_we | input | 1 | Assignment write strobe |
| cfg_addr | input | 5 | Assignment entry address |
| cfg_wdata | input | 9 | Enable flag and slot/sub-slot number |
| par_b_drv | input | 64 | Bearer bytes to drive, one per line and channel |
| par_d_drv | input | 8 | Signalling pairs to drive, one per line |
| par_b_cap | output | 64 | Bearer bytes captured in the previous frame |
| par_d_cap | output | 8 | Signalling pairs captured in the previous frame |
| par_valid | output | 1 | One-clock pulse when captured data is updated |

## Verification
The serial streams are compared bit by bit against a model across short, long and truncated frames. This separates off-by-one slot placement, wrong bit order within a byte or pair, and stale drive data.

Two pairs of conflicting drive entries, one bearer and one signalling, show whether priority follows line order. Disabling the winner then shows the fallback to the next claimant.

A frame that is longer than its predecessor shows that a slot beyond the previous length stays idle. The same slot is active one frame later. A sync pulse held over two bit clocks must not restart the count. Writes to unused addresses must leave the streams exactly as modelled.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    // One assignment entry: enable flag plus slot or sub-slot number
    typedef struct packed {
        logic       en;
        logic [7:0] num;
    } asg_t;

    // Entry kinds within one line; address = line * KINDS + kind
    typedef enum logic [2:0] {
        K_CAP_B1 = 3'd0,
        K_CAP_B2 = 3'd1,
        K_CAP_D  = 3'd2,
        K_DRV_B1 = 3'd3,
        K_DRV_B2 = 3'd4,
        K_DRV_D  = 3'd5
    } asg_kind_e;

    localparam int KINDS = 6;

    // True when bit position pos lies in the unit the entry names,
    // and that unit fits completely inside limit_bits.
    // sh = log2 of the unit size in bits (3 for bytes, 1 for pairs).
    function automatic logic unit_hit(asg_t a, int unsigned pos, int unsigned sh,
                                      int unsigned limit_bits);
        int unsigned idx;
        idx = pos >> sh;
        return a.en && (32'(a.num) == idx) && (((idx + 1) << sh) <= limit_bits);
    endfunction

endpackage

// File: rtl/tsm_timebase.sv
module tsm_timebase #(
    parameter int MAX_BITS = 512,
    parameter int CW       = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bclk,
    input  logic          fsync,
    output logic          fall_stb,
    output logic          drv_stb,
    output logic          frame_go,
    output logic          seen,
    output logic [CW-1:0] bit_cnt,
    output logic [CW-1:0] frame_bits
);
    localparam logic [CW-1:0] IDLE = CW'(MAX_BITS);

    logic bclk_q;
    logic fs_q;
    logic rise;

    assign rise     = bclk & ~bclk_q;
    assign fall_stb = ~bclk & bclk_q;
    assign frame_go = rise & fsync & ~fs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q     <= 1'b0;
            fs_q       <= 1'b0;
            drv_stb    <= 1'b0;
            seen       <= 1'b0;
            bit_cnt    <= IDLE;
            frame_bits <= IDLE;
        end else begin
            bclk_q  <= bclk;
            drv_stb <= rise;
            if (rise) begin
                fs_q <= fsync;
                if (frame_go) begin
                    bit_cnt <= '0;
                    seen    <= 1'b1;
                    if (seen)
                        frame_bits <= (bit_cnt == IDLE) ? IDLE : bit_cnt + 1'b1;
                end else if (bit_cnt != IDLE) begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R2: a frame start puts the counter on bit zero
    p_frame_zero_r2: assert property (@(posedge clk) disable iff (rst)
        frame_go |=> (bit_cnt == '0));

    // R2: each non-start rise advances one bit until the end of the frame
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (rise && !frame_go && bit_cnt != IDLE) |=> (bit_cnt == $past(bit_cnt) + 1'b1));

    // R2: the count moves only on a bit-clock rise
    p_count_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(bit_cnt));

endmodule

// File: rtl/tsm_capture.sv
module tsm_capture
    import tsm_pkg::*;
#(
    parameter int LINES = 4,
    parameter int CW    = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fall_stb,
    input  logic                 frame_go,
    input  logic                 seen,
    input  logic [CW-1:0]        bit_cnt,
    input  logic [CW-1:0]        frame_bits,
    input  logic                 ser_b_in,
    input  logic                 ser_d_in,
    input  asg_t                 regs [LINES*KINDS],
    output logic [LINES*16-1:0]  par_b_cap,
    output logic [LINES*2-1:0]   par_d_cap,
    output logic                 par_valid
);
    localparam int NB = LINES * 2;

    logic [7:0] b_sh   [NB];
    logic [7:0] b_hold [NB];
    logic [1:0] d_sh   [LINES];
    logic [1:0] d_hold [LINES];

    for (genvar c = 0; c < NB; c++) begin : g_b
        localparam int RI = (c / 2) * KINDS + int'(K_CAP_B1) + (c % 2);
        always_ff @(posedge clk) begin
            if (rst) begin
                b_sh[c]   <= '0;
                b_hold[c] <= '0;
            end else begin
                if (fall_stb && unit_hit(regs[RI], 32'(bit_cnt), 3, 32'(frame_bits)))
                    b_sh[c] <= {b_sh[c][6:0], ser_b_in};
                if (frame_go)
                    b_hold[c] <= b_sh[c];
            end
        end
        assign par_b_cap[c*8 +: 8] = b_hold[c];
    end

    for (genvar l = 0; l < LINES; l++) begin : g_d
        localparam int RI = l * KINDS + int'(K_CAP_D);
        always_ff @(posedge clk) begin
            if (rst) begin
                d_sh[l]   <= '0;
                d_hold[l] <= '0;
            end else begin
                if (fall_stb && unit_hit(regs[RI], 32'(bit_cnt), 1, 32'(frame_bits)))
                    d_sh[l] <= {d_sh[l][0], ser_d_in};
                if (frame_go)
                    d_hold[l] <= d_sh[l];
            end
        end
        assign par_d_cap[l*2 +: 2] = d_hold[l];
    end

    always_ff @(posedge clk) begin
        if (rst) par_valid <= 1'b0;
        else     par_valid <= frame_go & seen;
    end

    // R10: the valid strobe lasts a single clock
    p_valid_single_r10: assert property (@(posedge clk) disable iff (rst)
        par_valid |=> !par_valid);

    // R4: delivered bytes change only at a frame start
    p_b_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !frame_go |=> $stable(par_b_cap));

    // R6: delivered pairs change only at a frame start
    p_d_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !frame_go |=> $stable(par_d_cap));

endmodule

// File: rtl/tsm_driver.sv
module tsm_driver
    import tsm_pkg::*;
#(
    parameter int LINES = 4,
    parameter int CW    = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 drv_stb,
    input  logic                 frame_go,
    input  logic [CW-1:0]        bit_cnt,
    input  logic [CW-1:0]        frame_bits,
    input  asg_t                 regs [LINES*KINDS],
    input  logic [LINES*16-1:0]  par_b_drv,
    input  logic [LINES*2-1:0]   par_d_drv,
    output logic                 ser_b_out,
    output logic                 ser_b_oe,
    output logic                 ser_d_out,
    output logic                 ser_d_oe
);
    localparam int NB = LINES * 2;

    logic [LINES*16-1:0] b_lat;
    logic [LINES*2-1:0]  d_lat;
    logic                b_any, b_bit, d_any, d_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            b_lat <= '0;
            d_lat <= '0;
        end else if (frame_go) begin
            b_lat <= par_b_drv;
            d_lat <= par_d_drv;
        end
    end

    // Scan from the highest claimant down so the lowest one is kept
    always_comb begin
        b_any = 1'b0;
        b_bit = 1'b0;
        for (int c = NB - 1; c >= 0; c--) begin
            if (unit_hit(regs[(c / 2) * KINDS + int'(K_DRV_B1) + (c % 2)],
                         32'(bit_cnt), 3, 32'(frame_bits))) begin
                b_any = 1'b1;
                b_bit = b_lat[c*8 + 7 - int'(bit_cnt[2:0])];
            end
        end
        d_any = 1'b0;
        d_bit = 1'b0;
        for (int l = LINES - 1; l >= 0; l--) begin
            if (unit_hit(regs[l * KINDS + int'(K_DRV_D)],
                         32'(bit_cnt), 1, 32'(frame_bits))) begin
                d_any = 1'b1;
                d_bit = d_lat[l*2 + 1 - int'(bit_cnt[0])];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_b_oe  <= 1'b0;
            ser_b_out <= 1'b0;
            ser_d_oe  <= 1'b0;
            ser_d_out <= 1'b0;
        end else if (drv_stb) begin
            ser_b_oe  <= b_any;
            ser_b_out <= b_any & b_bit;
            ser_d_oe  <= d_any;
            ser_d_out <= d_any & d_bit;
        end
    end

    // R3: serial outputs move only after a bit-clock rise
    p_out_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
        !drv_stb |=> ($stable(ser_b_oe) && $stable(ser_b_out) &&
                      $stable(ser_d_oe) && $stable(ser_d_out)));

    // R9: no drive beyond the previous frame length
    p_limit_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (drv_stb && bit_cnt >= frame_bits) |=> (!ser_b_oe && !ser_d_oe));

    // R7: an undriven output stays low
    p_quiet_low_r7: assert property (@(posedge clk) disable iff (rst)
        (!ser_b_oe |-> !ser_b_out) and (!ser_d_oe |-> !ser_d_out));

endmodule

// File: rtl/tdm_slot_mapper.sv
module tdm_slot_mapper
    import tsm_pkg::*;
#(
    parameter int LINES     = 4,
    parameter int MAX_SLOTS = 64,
    localparam int MAX_BITS = MAX_SLOTS * 8,
    localparam int CW       = $clog2(MAX_BITS + 1),
    localparam int NREG     = LINES * KINDS,
    localparam int AW       = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bclk,
    input  logic                 fsync,
    input  logic                 ser_b_in,
    input  logic                 ser_d_in,
    output logic                 ser_b_out,
    output logic                 ser_b_oe,
    output logic                 ser_d_out,
    output logic                 ser_d_oe,
    input  logic                 cfg_we,
    input  logic [AW-1:0]        cfg_addr,
    input  logic [8:0]           cfg_wdata,
    input  logic [LINES*16-1:0]  par_b_drv,
    input  logic [LINES*2-1:0]   par_d_drv,
    output logic [LINES*16-1:0]  par_b_cap,
    output logic [LINES*2-1:0]   par_d_cap,
    output logic                 par_valid
);
    asg_t          regs [NREG];
    logic          fall_stb, drv_stb, frame_go, seen;
    logic [CW-1:0] bit_cnt, frame_bits;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst)
                regs[i] <= '0;
            else if (cfg_we && cfg_addr == AW'(i))
                regs[i] <= cfg_wdata;
        end
    end

    tsm_timebase #(.MAX_BITS(MAX_BITS), .CW(CW)) u_tb (
        .clk(clk), .rst(rst), .bclk(bclk), .fsync(fsync),
        .fall_stb(fall_stb), .drv_stb(drv_stb), .frame_go(frame_go),
        .seen(seen), .bit_cnt(bit_cnt), .frame_bits(frame_bits)
    );

    tsm_capture #(.LINES(LINES), .CW(CW)) u_cap (
        .clk(clk), .rst(rst), .fall_stb(fall_stb), .frame_go(frame_go),
        .seen(seen), .bit_cnt(bit_cnt), .frame_bits(frame_bits),
        .ser_b_in(ser_b_in), .ser_d_in(ser_d_in), .regs(regs),
        .par_b_cap(par_b_cap), .par_d_cap(par_d_cap), .par_valid(par_valid)
    );

    tsm_driver #(.LINES(LINES), .CW(CW)) u_drv (
        .clk(clk), .rst(rst), .drv_stb(drv_stb), .frame_go(frame_go),
        .bit_cnt(bit_cnt), .frame_bits(frame_bits), .regs(regs),
        .par_b_drv(par_b_drv), .par_d_drv(par_d_drv),
        .ser_b_out(ser_b_out), .ser_b_oe(ser_b_oe),
        .ser_d_out(ser_d_out), .ser_d_oe(ser_d_oe)
    );

    // R10: delivery strobe only at a frame start that has a predecessor
    p_valid_at_start_r10: assert property (@(posedge clk) disable iff (rst)
        par_valid |-> $past(frame_go));

endmodule

// File: tb/tdm_slot_mapper_test.sv
module tdm_slot_mapper_test;
    localparam int LINES = 4;
    localparam int NB    = 8;
    localparam int NREG  = 24;
    localparam int AW    = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1, bclk = 1'b0, fsync = 1'b0, sb_in = 1'b0, sd_in = 1'b0;
    logic cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [8:0] cfg_wdata = '0;
    logic [63:0] pb_drv = '0;
    logic [7:0]  pd_drv = '0;
    logic sb_out, sb_oe, sd_out, sd_oe, pv;
    logic [63:0] pb_cap;
    logic [7:0]  pd_cap;

    tdm_slot_mapper uut (
        .clk(clk), .rst(rst), .bclk(bclk), .fsync(fsync),
        .ser_b_in(sb_in), .ser_d_in(sd_in),
        .ser_b_out(sb_out), .ser_b_oe(sb_oe), .ser_d_out(sd_out), .ser_d_oe(sd_oe),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .par_b_drv(pb_drv), .par_d_drv(pd_drv),
        .par_b_cap(pb_cap), .par_d_cap(pd_cap), .par_valid(pv)
    );

    typedef struct packed { logic boe; logic b; logic doe; logic d; } bit_exp_t;
    typedef struct packed { logic [63:0] b; logic [7:0] d; } cap_exp_t;

    bit_exp_t bq[$];
    cap_exp_t cq[$];
    int n_cmp = 0, n_bad = 0, vcount = 0;
    logic smp_bit = 1'b0, smp_cap = 1'b0;
    bit finished = 1'b0;

    // bench model of the assignment entries and capture registers
    logic       m_en  [NREG];
    logic [7:0] m_num [NREG];
    logic [7:0] m_bsh [NB];
    logic [1:0] m_dsh [LINES];
    int  lim = 512;
    bit  have_prev = 1'b0;

    function automatic bit hit(int r, int pos, int sh);
        int idx = pos >> sh;
        return m_en[r] && (int'(m_num[r]) == idx) && (((idx + 1) << sh) <= lim);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(int a, bit en, int num);
        cfg_we = 1'b1;
        cfg_addr = AW'(a);
        cfg_wdata = {en, 8'(num)};
        tick();
        cfg_we = 1'b0;
        if (a < NREG) begin
            m_en[a] = en;
            m_num[a] = 8'(num);
        end
    endtask

    // driver: pushes expected items, then plays one frame of bits
    task automatic run_frame(int nbits, int fs_len, bit live);
        if (live && have_prev) begin
            cap_exp_t x;
            for (int c = 0; c < NB; c++) x.b[c*8 +: 8] = m_bsh[c];
            for (int l = 0; l < LINES; l++) x.d[l*2 +: 2] = m_dsh[l];
            cq.push_back(x);
        end
        for (int n = 0; n < nbits; n++) begin
            bit_exp_t e;
            e = '0;
            if (live) begin
                for (int c = NB - 1; c >= 0; c--)
                    if (hit((c / 2) * 6 + 3 + (c % 2), n, 3)) begin
                        e.boe = 1'b1;
                        e.b = pb_drv[c*8 + 7 - (n % 8)];
                    end
                for (int l = LINES - 1; l >= 0; l--)
                    if (hit(l * 6 + 5, n, 1)) begin
                        e.doe = 1'b1;
                        e.d = pd_drv[l*2 + 1 - (n % 2)];
                    end
            end
            bq.push_back(e);
            bclk = 1'b1;
            fsync = (n < fs_len);
            sb_in = 1'($urandom % 2);
            sd_in = 1'($urandom % 2);
            tick(); tick(); tick();
            smp_bit = 1'b1;
            smp_cap = live && have_prev && (n == 0);
            tick();
            smp_bit = 1'b0;
            smp_cap = 1'b0;
            bclk = 1'b0;
            if (live) begin
                for (int c = 0; c < NB; c++)
                    if (hit((c / 2) * 6 + (c % 2), n, 3)) m_bsh[c] = {m_bsh[c][6:0], sb_in};
                for (int l = 0; l < LINES; l++)
                    if (hit(l * 6 + 2, n, 1)) m_dsh[l] = {m_dsh[l][0], sd_in};
            end
            tick(); tick(); tick(); tick();
        end
        if (live) begin
            lim = (nbits > 512) ? 512 : nbits;
            have_prev = 1'b1;
        end
    endtask

    // monitor: pops expected items and compares at the sample points
    always @(negedge clk) begin
        if (smp_bit) begin
            bit_exp_t a, e;
            a = '{sb_oe, sb_out, sd_oe, sd_out};
            n_cmp++;
            if (bq.size() == 0) begin
                n_bad++;
                $display("FAIL R2/R3/R5/R7/R8/R9/R11 stream: actual %b expected none", a);
            end else begin
                e = bq.pop_front();
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL R2/R3/R5/R7/R8/R9/R11 stream {boe,b,doe,d}: actual %b expected %b", a, e);
                end
            end
        end
        if (smp_cap) begin
            cap_exp_t a, e;
            a = {pb_cap, pd_cap};
            n_cmp++;
            if (cq.size() == 0) begin
                n_bad++;
                $display("FAIL R4/R6 capture: actual %h expected none", a);
            end else begin
                e = cq.pop_front();
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL R4/R6 capture: actual %h expected %h", a, e);
                end
            end
        end
        if (!rst && pv) vcount++;
    end

    task automatic check(bit ok, string tag, logic [71:0] act, logic [71:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) begin m_en[i] = 1'b0; m_num[i] = '0; end
        for (int c = 0; c < NB; c++) m_bsh[c] = '0;
        for (int l = 0; l < LINES; l++) m_dsh[l] = '0;
        repeat (4) tick();
        // R1: reset state
        check({sb_oe, sd_oe, sb_out, sd_out, pv} == 5'b0, "R1 outputs in reset",
              72'({sb_oe, sd_oe, sb_out, sd_out, pv}), 72'(0));
        rst = 1'b0;
        tick();
        check({pb_cap, pd_cap} == 72'b0, "R1 capture after reset", {pb_cap, pd_cap}, 72'(0));
        check({sb_oe, sd_oe, pv} == 3'b0, "R1 enables after reset", 72'({sb_oe, sd_oe, pv}), 72'(0));

        // R7: bit clocks before any frame drive nothing
        run_frame(4, 0, 1'b0);

        // R11 writes; R8 conflicts on B slot 2 and D sub-slot 5
        wr(0*6+3, 1, 1);  wr(1*6+4, 1, 2);  wr(2*6+3, 1, 2);
        wr(3*6+5, 1, 5);  wr(0*6+5, 1, 5);  wr(1*6+5, 1, 0);
        wr(3*6+1, 1, 0);  wr(0*6+0, 1, 3);  wr(2*6+2, 1, 7);  wr(1*6+2, 1, 0);
        pb_drv = 64'hA5C3_3C5A_0FF0_96E1;
        pd_drv = 8'b10_01_11_01;
        run_frame(32, 1, 1'b1);                      // first frame
        pb_drv = 64'h1248_8421_F00F_6699;
        pd_drv = 8'b01_10_00_11;
        run_frame(32, 1, 1'b1);                      // R4/R6 delivery

        wr(1*6+4, 0, 2);                             // R8: winner removed
        wr(27, 1, 0);  wr(31, 1, 3);                 // R11: unused addresses
        wr(3*6+3, 1, 5);                             // R9: slot 5 beyond 32 bits
        pb_drv = 64'hDEAD_BEEF_5A5A_C001;
        run_frame(64, 2, 1'b1);                      // R2: sync held two rises
        run_frame(64, 1, 1'b1);                      // slot 5 now in range
        wr(2*6+2, 1, 20);
        run_frame(16, 1, 1'b1);                      // short frame
        pd_drv = 8'b11_00_10_01;
        run_frame(64, 1, 1'b1);                      // R9: limit 16 bits
        run_frame(8, 1, 1'b1);

        // R10: seven frames give six delivery strobes
        check(vcount == 6, "R10 valid pulses", 72'(vcount), 72'(6));
        check(bq.size() == 0 && cq.size() == 0, "R2 leftover expectations",
              72'(bq.size() + cq.size()), 72'(0));
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule